// File: doc/BRIEF.md
# Maskable Two-Level Interrupt Controller

This block gathers a set of level-sensitive interrupt request lines and turns them into two processor request outputs: a fast request and a normal request. Every source owns three bits: a raw pending bit that copies its line once per clock, an enable bit, and a route bit. A source that is pending and enabled counts as qualified. Its route bit then places it in either the fast pending view or the normal pending view. Each output is the registered OR of its view.

While the core reports idle, a control bit decides whether the enable bits still apply. With that bit clear, any pending source counts as qualified, so any request wakes the core. With it set, idle behaves like run mode. Software configures the block and polls raw pending bits through a small synchronous register port. Writes take effect on the clock edge, and read data is a combinational function of the address.

Top module: `fq_intc`

## Requirements
- R1: After reset, every register reads 0 and both `fiq_o` and `irq_o` are low.
- R2: The raw pending register (word offset 0x10) holds the value of `src_i` sampled at the previous clock edge, whatever the enable bits are. Writes to it are ignored.
- R3: Outside the idle-open condition of R6, a source whose enable bit (offset 0x04) is 0 does not appear in either pending view and does not raise either output.
- R4: A qualified source appears in the fast pending view (offset 0x0C) when its route bit (offset 0x08) is 1, and in the normal pending view (offset 0x00) when its route bit is 0. It never appears in both.
- R5: `fiq_o` is 1 exactly one clock after the fast pending view is non-zero, and `irq_o` likewise follows the normal pending view.
- R6: While `idle_i` is 1 and control bit 0 (offset 0x14) is 0, every raw pending source is qualified whatever its enable bit is.
- R7: While `idle_i` is 1 and control bit 0 is 1, the enable bits apply as in run mode.
- R8: Only the enable, route and control words are writable. Bits above the source count and control bits above bit 0 read 0. Misaligned addresses and offsets 0x18 and 0x1C read 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| src_i | input | 25 | Level-sensitive request lines |
| idle_i | input | 1 | Core idle indication |
| addr_i | input | 5 | Register byte address |
| wr_en_i | input | 1 | Write strobe, sampled on the clock edge |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i` |
| fiq_o | output | 1 | Fast interrupt request, active high, registered |
| irq_o | output | 1 | Normal interrupt request, active high, registered |

## Verification
A configuration write and a change on the request lines can land on the same clock edge. The result then depends on the new enable bits meeting the newly sampled sources. The bench provokes this in every random round by driving a new random enable word in the same cycle as fresh random sources and a random idle level. Two edges later it compares both outputs and both pending views with values its reference function computes from the written words. Directed cases repeat the collision at the idle boundary, with the control bit set and with it cleared.

// File: rtl/fq_intc_pkg.sv
package fq_intc_pkg;
  localparam int unsigned ADDR_W = 5;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned IDX_W  = 3;

  typedef enum logic [IDX_W-1:0] {
    IDX_NORM_PEND = 3'd0,
    IDX_ENABLE    = 3'd1,
    IDX_ROUTE     = 3'd2,
    IDX_FAST_PEND = 3'd3,
    IDX_RAW_PEND  = 3'd4,
    IDX_CONTROL   = 3'd5,
    IDX_SPARE6    = 3'd6,
    IDX_SPARE7    = 3'd7
  } reg_idx_e;
endpackage

// File: rtl/fq_intc_rst_sync.sv
module fq_intc_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_o
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb chain_d = {chain_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_n_o = chain_q[STAGES-1];
endmodule

// File: rtl/fq_intc_cfg_regs.sv
module fq_intc_cfg_regs
  import fq_intc_pkg::*;
#(
  parameter int unsigned NSRC = 25
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en_i,
  input  logic            aligned_i,
  input  reg_idx_e        widx_i,
  input  logic [NSRC-1:0] wdata_i,
  output logic [NSRC-1:0] enable_o,
  output logic [NSRC-1:0] route_o,
  output logic            dim_o
);
  logic [NSRC-1:0] enable_q, enable_d;
  logic [NSRC-1:0] route_q,  route_d;
  logic            dim_q,    dim_d;
  logic            en_wr, rt_wr, ct_wr;

  always_comb begin
    en_wr    = wr_en_i && aligned_i && (widx_i == IDX_ENABLE);
    rt_wr    = wr_en_i && aligned_i && (widx_i == IDX_ROUTE);
    ct_wr    = wr_en_i && aligned_i && (widx_i == IDX_CONTROL);
    enable_d = en_wr ? wdata_i    : enable_q;
    route_d  = rt_wr ? wdata_i    : route_q;
    dim_d    = ct_wr ? wdata_i[0] : dim_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enable_q <= '0;
      route_q  <= '0;
      dim_q    <= 1'b0;
    end else begin
      enable_q <= enable_d;
      route_q  <= route_d;
      dim_q    <= dim_d;
    end
  end

  assign enable_o = enable_q;
  assign route_o  = route_q;
  assign dim_o    = dim_q;

  // R8: the enable word changes only through its own aligned write
  p_enable_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en_i && aligned_i && widx_i == IDX_ENABLE) |=> $stable(enable_o));
  // R8: the control bit changes only through its own aligned write
  p_dim_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en_i && aligned_i && widx_i == IDX_CONTROL) |=> $stable(dim_o));
endmodule

// File: rtl/fq_intc_route.sv
module fq_intc_route #(
  parameter int unsigned NSRC = 25
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_i,
  input  logic            idle_i,
  input  logic [NSRC-1:0] enable_i,
  input  logic [NSRC-1:0] route_i,
  input  logic            dim_i,
  output logic [NSRC-1:0] raw_o,
  output logic [NSRC-1:0] fast_pend_o,
  output logic [NSRC-1:0] norm_pend_o,
  output logic            fiq_o,
  output logic            irq_o
);
  logic [NSRC-1:0] raw_q;
  logic [NSRC-1:0] qual;
  logic            open_gate;
  logic            fiq_q, fiq_d;
  logic            irq_q, irq_d;

  always_comb begin
    open_gate   = idle_i && !dim_i;
    qual        = open_gate ? raw_q : (raw_q & enable_i);
    fast_pend_o = qual & route_i;
    norm_pend_o = qual & ~route_i;
    fiq_d       = |fast_pend_o;
    irq_d       = |norm_pend_o;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw_q <= '0;
      fiq_q <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      raw_q <= src_i;
      fiq_q <= fiq_d;
      irq_q <= irq_d;
    end
  end

  assign raw_o = raw_q;
  assign fiq_o = fiq_q;
  assign irq_o = irq_q;

  // R3: disabled sources stay out of both views unless the idle gate is open
  p_masked_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!idle_i || dim_i) |-> (((fast_pend_o | norm_pend_o) & ~enable_i) == '0));
  // R4: the two views never share a source
  p_disjoint_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((fast_pend_o & norm_pend_o) == '0));
  // R5: a rising fast request is backed by a non-empty view one cycle earlier
  p_fiq_backed_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fiq_o) |-> $past(fast_pend_o != '0));
  // R5: a rising normal request is backed by a non-empty view one cycle earlier
  p_irq_backed_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> $past(norm_pend_o != '0));
  // R6: with the gate open every raw bit lands in exactly one view
  p_idle_open_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_i && !dim_i) |-> ((fast_pend_o | norm_pend_o) == raw_o));
endmodule

// File: rtl/fq_intc.sv
module fq_intc
  import fq_intc_pkg::*;
#(
  parameter int unsigned NSRC = 25
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   src_i,
  input  logic              idle_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              fiq_o,
  output logic              irq_o
);
  localparam int unsigned PAD_W = DATA_W - NSRC;

  logic            rst_n_s;
  logic            aligned;
  reg_idx_e        idx;
  logic [NSRC-1:0] enable, route, raw, fast_pend, norm_pend;
  logic            dim;

  assign aligned = (addr_i[1:0] == 2'b00);
  assign idx     = reg_idx_e'(addr_i[ADDR_W-1:2]);

  fq_intc_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_o(rst_n_s)
  );

  fq_intc_cfg_regs #(.NSRC(NSRC)) u_cfg (
    .clk(clk), .rst_n(rst_n_s), .wr_en_i(wr_en_i), .aligned_i(aligned),
    .widx_i(idx), .wdata_i(wdata_i[NSRC-1:0]),
    .enable_o(enable), .route_o(route), .dim_o(dim)
  );

  fq_intc_route #(.NSRC(NSRC)) u_route (
    .clk(clk), .rst_n(rst_n_s), .src_i(src_i), .idle_i(idle_i),
    .enable_i(enable), .route_i(route), .dim_i(dim),
    .raw_o(raw), .fast_pend_o(fast_pend), .norm_pend_o(norm_pend),
    .fiq_o(fiq_o), .irq_o(irq_o)
  );

  always_comb begin
    rdata_o = '0;
    if (aligned) begin
      unique case (idx)
        IDX_NORM_PEND: rdata_o = {{PAD_W{1'b0}}, norm_pend};
        IDX_ENABLE:    rdata_o = {{PAD_W{1'b0}}, enable};
        IDX_ROUTE:     rdata_o = {{PAD_W{1'b0}}, route};
        IDX_FAST_PEND: rdata_o = {{PAD_W{1'b0}}, fast_pend};
        IDX_RAW_PEND:  rdata_o = {{PAD_W{1'b0}}, raw};
        IDX_CONTROL:   rdata_o = {{(DATA_W-1){1'b0}}, dim};
        default:       rdata_o = '0;
      endcase
    end
  end

  // R1: while reset is held, both requests are low
  p_reset_quiet_r1: assert property (@(posedge clk)
    !rst_n_s |=> (!fiq_o && !irq_o));
endmodule

// File: tb/fq_intc_tb.sv
module fq_intc_tb;
  localparam int unsigned NSRC   = 25;
  localparam time         CLK_PER = 10ns;
  localparam logic [31:0] SMASK  = 32'h01FF_FFFF;

  localparam logic [4:0] A_NORM = 5'h00, A_EN = 5'h04, A_RT = 5'h08,
                         A_FAST = 5'h0C, A_RAW = 5'h10, A_CTL = 5'h14;

  logic              clk = 1'b0;
  logic              rst_n;
  logic [NSRC-1:0]   src;
  logic              idle;
  logic [4:0]        addr;
  logic              wr_en;
  logic [31:0]       wdata;
  logic [31:0]       rdata;
  logic              fiq, irq;

  int unsigned total = 0;
  int unsigned bad   = 0;
  bit          done  = 0;

  logic [31:0] m_en, m_rt;
  logic        m_dim;

  fq_intc #(.NSRC(NSRC)) u_dut (
    .clk(clk), .rst_n(rst_n), .src_i(src), .idle_i(idle), .addr_i(addr),
    .wr_en_i(wr_en), .wdata_i(wdata), .rdata_o(rdata), .fiq_o(fiq), .irq_o(irq)
  );

  always #(CLK_PER/2) clk = ~clk;

  function automatic logic [31:0] qual_f(logic [31:0] r, logic [31:0] e, logic d, logic idl);
    return (idl && !d) ? r : (r & e);
  endfunction
  function automatic logic [31:0] fast_f(logic [31:0] r, logic [31:0] e, logic [31:0] t, logic d, logic idl);
    return qual_f(r, e, d, idl) & t & SMASK;
  endfunction
  function automatic logic [31:0] norm_f(logic [31:0] r, logic [31:0] e, logic [31:0] t, logic d, logic idl);
    return qual_f(r, e, d, idl) & ~t & SMASK;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [4:0] a, logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(logic [4:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; wr_en = 1'b0;
    #1 d = rdata;
  endtask

  task automatic settle2;
    @(posedge clk); @(posedge clk); @(negedge clk);
  endtask

  task automatic check_all(string req);
    logic [31:0] v, r, f, n;
    r = {7'd0, src};
    f = fast_f(r, m_en, m_rt, m_dim, idle);
    n = norm_f(r, m_en, m_rt, m_dim, idle);
    chk({req, " fiq_o"}, {31'd0, fiq}, {31'd0, (f != 0)});
    chk({req, " irq_o"}, {31'd0, irq}, {31'd0, (n != 0)});
    rd(A_RAW, v);  chk({req, " R2 raw"}, v, r);
    rd(A_FAST, v); chk({req, " R4 fast view"}, v, f);
    rd(A_NORM, v); chk({req, " R4 norm view"}, v, n);
  endtask

  initial begin
    int unsigned cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        bad++; total++;
        $display("FAIL watchdog actual=%0d expected<=100000 cycles", cyc);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'd4242));
    rst_n = 1'b0; src = '0; idle = 1'b0; addr = '0; wr_en = 1'b0; wdata = '0;
    m_en = '0; m_rt = '0; m_dim = 1'b0;
    repeat (4) @(negedge clk);
    // R1: outputs low while reset is held
    chk("R1 fiq in reset", {31'd0, fiq}, 32'd0);
    chk("R1 irq in reset", {31'd0, irq}, 32'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1: every register reads zero after reset
    for (int a = 0; a < 6; a++) begin
      rd(5'(a * 4), v);
      chk("R1 register zero", v, 32'd0);
    end

    // R8: unused bits read zero, writable words hold
    wr(A_EN, 32'hFFFF_FFFF); rd(A_EN, v); chk("R8 enable width", v, SMASK);
    wr(A_RT, 32'hFFFF_FFFF); rd(A_RT, v); chk("R8 route width", v, SMASK);
    wr(A_CTL, 32'hFFFF_FFFF); rd(A_CTL, v); chk("R8 control width", v, 32'd1);
    wr(A_CTL, 32'h0); wr(A_EN, 32'h0); wr(A_RT, 32'h0);
    // R8: misaligned and spare writes ignored, reads zero
    wr(5'h05, 32'hFFFF_FFFF); rd(A_EN, v); chk("R8 misaligned write", v, 32'd0);
    wr(5'h18, 32'hFFFF_FFFF); rd(5'h18, v); chk("R8 spare 0x18", v, 32'd0);
    rd(5'h1C, v); chk("R8 spare 0x1C", v, 32'd0);

    // R2/R3: masked source stays visible but quiet
    @(negedge clk); src = 25'h0000_0F0;
    settle2; check_all("R3 all masked");
    // R2: writes to raw view ignored
    wr(A_RAW, 32'h0); rd(A_RAW, v); chk("R2 raw read-only", v, 32'h0000_00F0);
    wr(A_FAST, 32'hFFFF_FFFF); wr(A_NORM, 32'hFFFF_FFFF);
    rd(A_FAST, v); chk("R2 fast read-only", v, 32'd0);

    // R4: route split
    wr(A_EN, 32'h0000_0030); m_en = 32'h30;
    wr(A_RT, 32'h0000_0010); m_rt = 32'h10;
    settle2; check_all("R4 route split");

    // R6: idle with control clear opens the gate
    @(negedge clk); idle = 1'b1; src = 25'h1_000_001;
    settle2; check_all("R6 idle open");
    // R7: idle with control set keeps the mask
    wr(A_CTL, 32'h1); m_dim = 1'b1;
    settle2; check_all("R7 idle masked");
    // collision: control clears in same cycle as idle falls and source changes
    @(negedge clk); addr = A_CTL; wdata = 32'h0; wr_en = 1'b1; idle = 1'b0;
    src = 25'h0_000_020; m_dim = 1'b0;
    @(negedge clk); wr_en = 1'b0;
    @(posedge clk); @(negedge clk);
    check_all("R5 collision run");

    // random rounds: enable write collides with new sources and idle level
    for (int i = 0; i < 300; i++) begin
      if (i % 5 == 0) begin
        m_rt = $urandom & SMASK;  wr(A_RT, m_rt);
        m_dim = 1'($urandom);     wr(A_CTL, {31'd0, m_dim});
      end
      @(negedge clk);
      m_en  = $urandom & SMASK;
      addr  = A_EN; wdata = m_en | 32'hFE00_0000; wr_en = 1'b1;
      src   = NSRC'($urandom);
      idle  = 1'($urandom);
      @(negedge clk); wr_en = 1'b0;
      @(posedge clk); @(negedge clk);
      check_all("R5 random");
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule